// File: doc/BRIEF.md
# Decision-Tree Peripheral ID Lookup Engine

This block turns a 12-bit peripheral identifier into an 8-bit slot index. The identifier is a 4-bit slave number in the upper bits and an 8-bit peripheral number in the lower bits. The engine does not use a CAM or a hash. It walks a binary decision tree held in a 255-node table. Each node tests one bit of the identifier. It then either hands the walk to a child node or ends it with a slot number. A second table gives each of the 256 slots a 3-bit owner. A slot found by the walk is only returned when its owner equals the owner named in the request.

Both tables are loaded through a single write port before any lookups are issued. Once loaded, a requester presents an identifier and an owner while the engine is idle. The engine visits one node per clock cycle. When the walk ends it raises a one-cycle done pulse that carries a 9-bit result. The result is either the slot index or the failure code 256. A separate flag marks failures that came from the owner comparison.

Top module: `tree_id_lookup`

## Requirements
- R1: After reset, `rspValid` is 0 and `reqReady` is 1.
- R2: A node word holds the tested identifier bit number in bits [21:18]. The walk always begins at node 0. An identifier bit number of 12 to 15 reads as 0.
- R3: When the tested bit is 0, the node uses flag bit 17 and result [16:9]. When it is 1, the node uses flag bit 8 and result [7:0]. A flag of 1 makes the result the next node index. A flag of 0 makes the result the final slot.
- R4: A walk that reaches no terminal branch within 16 node visits fails with result 256. A terminal branch reached on the 16th visit still succeeds.
- R5: Visiting a node index of 255 fails at once with result 256. That visit counts toward the latency.
- R6: On a terminal branch, the slot's 3-bit owner is compared with `reqOwner`. On a match the slot is returned and `rspOwnerMismatch` is 0. On a mismatch the result is 256 and `rspOwnerMismatch` is 1. Every other failure leaves `rspOwnerMismatch` at 0.
- R7: `rspValid` pulses high for one cycle. The pulse comes exactly N cycles after the accepting clock edge, where N is the number of nodes visited. `rspSlot` and `rspOwnerMismatch` hold their values until the next response.
- R8: A request is accepted only while `reqReady` is 1. `reqReady` is 0 for the whole walk, and requests made while busy are dropped.
- R9: Table writes made while a walk is in progress have no effect.
- R10: With `tblWrSel`=0, a write stores the 32-bit word into node `tblWrAddr` for addresses 0 to 254. With `tblWrSel`=1, it stores bits [2:0] of the data as the owner of slot `tblWrAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tblWrEn | input | 1 | Table write strobe |
| tblWrSel | input | 1 | 0 selects the node table, 1 selects the owner table |
| tblWrAddr | input | 8 | Node or slot address |
| tblWrData | input | 32 | Node word, or owner in bits [2:0] |
| reqValid | input | 1 | Lookup request |
| reqId | input | 12 | Identifier to translate |
| reqOwner | input | 3 | Owner the resulting slot must have |
| reqReady | output | 1 | Engine idle, so a request is taken |
| rspValid | output | 1 | One-cycle done pulse |
| rspSlot | output | 9 | Slot index, or 256 on failure |
| rspOwnerMismatch | output | 1 | Failure was caused by the owner comparison |

## Verification
The lookups use randomly filled trees in which about 60% of the branches continue. This mix produces shallow hits, deep walks, cycles that hit the visit limit, and random owner matches and mismatches. A bench model predicts the slot, the flag and the latency for each lookup. Directed trees then separate the cases the random mix cannot pin down:
- a 16-deep chain ending on its last node versus a self-loop, which separates success at the limit from failure;
- a jump to node 255, which must fail on the second visit;
- a test of bit 13, which must take the zero branch;
- owner words with junk upper bits.

Requests and table writes issued in the middle of a long walk must leave no trace. A second response must not appear, and later lookups must still reflect the old table contents.

// File: rtl/tree_lookup_pkg.sv
package tree_lookup_pkg;

  // Node word field positions; the walk decodes these directly.
  localparam int BIT_SEL_LSB  = 18;
  localparam int BIT_SEL_W    = 4;
  localparam int ZERO_FLAG    = 17;
  localparam int ZERO_RES_LSB = 9;
  localparam int ONE_FLAG     = 8;
  localparam int ONE_RES_LSB  = 0;

  // Control to datapath
  typedef struct packed {
    logic captureReq;
    logic advance;
    logic finishHit;
    logic finishMiss;
  } ctrlStrobes_t;

  // Datapath to control
  typedef struct packed {
    logic terminal;
    logic badIndex;
  } dpStatus_t;

endpackage

// File: rtl/tree_lookup_ctrl.sv
module tree_lookup_ctrl
  import tree_lookup_pkg::*;
#(
  parameter int MAX_VISITS = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes,
  output logic         reqReady,
  output logic         walkActive
);
  localparam int VCNT_W = $clog2(MAX_VISITS + 1);
  localparam logic [VCNT_W-1:0] LAST_VISIT = VCNT_W'(MAX_VISITS - 1);

  typedef enum logic {ST_IDLE, ST_WALK} walkState_t;

  walkState_t        state;
  logic [VCNT_W-1:0] visitCnt;

  always_comb begin
    strobes = '0;
    unique case (state)
      ST_IDLE: strobes.captureReq = reqValid;
      ST_WALK: begin
        if (status.badIndex)           strobes.finishMiss = 1'b1;
        else if (status.terminal)      strobes.finishHit  = 1'b1;
        else if (visitCnt == LAST_VISIT) strobes.finishMiss = 1'b1;
        else                           strobes.advance    = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      visitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state    <= ST_WALK;
          visitCnt <= '0;
        end
        ST_WALK: begin
          if (strobes.finishHit || strobes.finishMiss) state <= ST_IDLE;
          if (strobes.advance) visitCnt <= visitCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady   = (state == ST_IDLE);
  assign walkActive = (state == ST_WALK);

  AST_VISIT_CAP: assert property (@(posedge clk) disable iff (!rstN)
    walkActive |-> (visitCnt < VCNT_W'(MAX_VISITS))); // R4
  AST_BUSY_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqReady) |-> $past(reqValid)); // R8
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.advance, strobes.finishHit, strobes.finishMiss})); // R3

endmodule

// File: rtl/tree_lookup_dp.sv
module tree_lookup_dp
  import tree_lookup_pkg::*;
#(
  parameter int ID_W       = 12,
  parameter int SLOT_W     = 8,
  parameter int OWNER_W    = 3,
  parameter int NODE_COUNT = 255,
  parameter int NODE_W     = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic               walkActive,
  output dpStatus_t          status,
  input  logic               tblWrEn,
  input  logic               tblWrSel,
  input  logic [SLOT_W-1:0]  tblWrAddr,
  input  logic [NODE_W-1:0]  tblWrData,
  input  logic [ID_W-1:0]    reqId,
  input  logic [OWNER_W-1:0] reqOwner,
  output logic               rspValid,
  output logic [SLOT_W:0]    rspSlot,
  output logic               rspOwnerMismatch
);
  localparam int SLOTS   = 1 << SLOT_W;
  localparam int WIDE_ID = 1 << BIT_SEL_W;
  localparam logic [SLOT_W:0] NODE_LIMIT = (SLOT_W+1)'(NODE_COUNT);
  localparam logic [SLOT_W:0] FAIL_CODE  = (SLOT_W+1)'(SLOTS);
  localparam int USED_TOP = BIT_SEL_LSB + BIT_SEL_W;

  logic [NODE_W-1:0]  nodeMem  [NODE_COUNT];
  logic [OWNER_W-1:0] ownerMem [SLOTS];

  logic [ID_W-1:0]    idReg;
  logic [OWNER_W-1:0] ownerReg;
  logic [SLOT_W-1:0]  nodeIdx;

  logic [NODE_W-1:0]    curNode;
  logic [BIT_SEL_W-1:0] bitSel;
  logic [WIDE_ID-1:0]   idWide;
  logic                 testBit;
  logic                 takenFlag;
  logic [SLOT_W-1:0]    takenRes;
  logic                 ownerOk;
  logic                 idxInRange;
  logic                 unusedNodeBits;

  // Table loading, blocked while a walk runs
  always_ff @(posedge clk) begin
    if (tblWrEn && !walkActive) begin
      if (!tblWrSel) begin
        if ({1'b0, tblWrAddr} < NODE_LIMIT) nodeMem[tblWrAddr] <= tblWrData;
      end else begin
        ownerMem[tblWrAddr] <= tblWrData[OWNER_W-1:0];
      end
    end
  end

  // Node decode
  assign idxInRange = ({1'b0, nodeIdx} < NODE_LIMIT);
  assign curNode    = idxInRange ? nodeMem[nodeIdx] : '0;
  assign bitSel     = curNode[BIT_SEL_LSB +: BIT_SEL_W];
  assign idWide     = {{(WIDE_ID-ID_W){1'b0}}, idReg};
  assign testBit    = idWide[bitSel];
  assign takenFlag  = testBit ? curNode[ONE_FLAG] : curNode[ZERO_FLAG];
  assign takenRes   = testBit ? curNode[ONE_RES_LSB +: SLOT_W]
                              : curNode[ZERO_RES_LSB +: SLOT_W];
  assign ownerOk    = (ownerMem[takenRes] == ownerReg);
  assign unusedNodeBits = ^curNode[NODE_W-1:USED_TOP];

  assign status.terminal = !takenFlag;
  assign status.badIndex = !idxInRange;

  // Walk registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idReg    <= '0;
      ownerReg <= '0;
      nodeIdx  <= '0;
    end else if (strobes.captureReq) begin
      idReg    <= reqId;
      ownerReg <= reqOwner;
      nodeIdx  <= '0;
    end else if (strobes.advance) begin
      nodeIdx  <= takenRes;
    end
  end

  // Response registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid         <= 1'b0;
      rspSlot          <= '0;
      rspOwnerMismatch <= 1'b0;
    end else begin
      rspValid <= strobes.finishHit | strobes.finishMiss;
      if (strobes.finishHit) begin
        rspSlot          <= ownerOk ? {1'b0, takenRes} : FAIL_CODE;
        rspOwnerMismatch <= !ownerOk;
      end else if (strobes.finishMiss) begin
        rspSlot          <= FAIL_CODE;
        rspOwnerMismatch <= 1'b0;
      end
    end
  end

  AST_MISMATCH_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspOwnerMismatch) |-> (rspSlot == FAIL_CODE)); // R6
  AST_FAIL_FORM: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspSlot[SLOT_W]) |-> (rspSlot[SLOT_W-1:0] == '0)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> $stable(rspSlot)); // R7

endmodule

// File: rtl/tree_id_lookup.sv
module tree_id_lookup
  import tree_lookup_pkg::*;
#(
  parameter int ID_W       = 12,
  parameter int SLOT_W     = 8,
  parameter int OWNER_W    = 3,
  parameter int NODE_COUNT = 255,
  parameter int NODE_W     = 32,
  parameter int MAX_VISITS = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tblWrEn,
  input  logic               tblWrSel,
  input  logic [SLOT_W-1:0]  tblWrAddr,
  input  logic [NODE_W-1:0]  tblWrData,
  input  logic               reqValid,
  input  logic [ID_W-1:0]    reqId,
  input  logic [OWNER_W-1:0] reqOwner,
  output logic               reqReady,
  output logic               rspValid,
  output logic [SLOT_W:0]    rspSlot,
  output logic               rspOwnerMismatch
);
  ctrlStrobes_t strobes;
  dpStatus_t    status;
  logic         walkActive;

  tree_lookup_ctrl #(.MAX_VISITS(MAX_VISITS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .status     (status),
    .strobes    (strobes),
    .reqReady   (reqReady),
    .walkActive (walkActive)
  );

  tree_lookup_dp #(
    .ID_W(ID_W), .SLOT_W(SLOT_W), .OWNER_W(OWNER_W),
    .NODE_COUNT(NODE_COUNT), .NODE_W(NODE_W)
  ) u_dp (
    .clk              (clk),
    .rstN             (rstN),
    .strobes          (strobes),
    .walkActive       (walkActive),
    .status           (status),
    .tblWrEn          (tblWrEn),
    .tblWrSel         (tblWrSel),
    .tblWrAddr        (tblWrAddr),
    .tblWrData        (tblWrData),
    .reqId            (reqId),
    .reqOwner         (reqOwner),
    .rspValid         (rspValid),
    .rspSlot          (rspSlot),
    .rspOwnerMismatch (rspOwnerMismatch)
  );

endmodule

// File: tb/tree_id_lookup_tb.sv
module tree_id_lookup_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tblWrEn = 1'b0;
  logic        tblWrSel = 1'b0;
  logic [7:0]  tblWrAddr = '0;
  logic [31:0] tblWrData = '0;
  logic        reqValid = 1'b0;
  logic [11:0] reqId = '0;
  logic [2:0]  reqOwner = '0;
  logic        reqReady, rspValid, rspOwnerMismatch;
  logic [8:0]  rspSlot;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [31:0] mdlNode [255];
  logic [2:0]  mdlOwner [256];

  always #10 clk = ~clk; // 50 MHz

  tree_id_lookup u_dut (
    .clk(clk), .rstN(rstN), .tblWrEn(tblWrEn), .tblWrSel(tblWrSel),
    .tblWrAddr(tblWrAddr), .tblWrData(tblWrData), .reqValid(reqValid),
    .reqId(reqId), .reqOwner(reqOwner), .reqReady(reqReady),
    .rspValid(rspValid), .rspSlot(rspSlot), .rspOwnerMismatch(rspOwnerMismatch)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkNode(input int bi, input bit zf, input int zr,
                                         input bit of1, input int or1);
    logic [31:0] n = '0;
    n[21:18] = 4'(bi); n[17] = zf; n[16:9] = 8'(zr); n[8] = of1; n[7:0] = 8'(or1);
    return n;
  endfunction

  // Reference: slot result, visit count, mismatch flag
  function automatic int refLookup(input logic [11:0] id, input logic [2:0] own,
                                   output int visits, output bit mis);
    int idx = 0;
    mis = 0;
    for (int v = 1; v <= 16; v++) begin
      logic [31:0] n;
      bit b, fl;
      int res, bi;
      visits = v;
      if (idx >= 255) return 256;
      n  = mdlNode[idx];
      bi = int'(n[21:18]);
      b  = (bi < 12) ? id[bi] : 1'b0;
      fl = b ? n[8] : n[17];
      res = b ? int'(n[7:0]) : int'(n[16:9]);
      if (!fl) begin
        if (mdlOwner[res] == own) return res;
        mis = 1;
        return 256;
      end
      idx = res;
    end
    visits = 16;
    return 256;
  endfunction

  task automatic wr(input bit sel, input int addr, input logic [31:0] data, input bit apply);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrSel = sel; tblWrAddr = 8'(addr); tblWrData = data;
    @(posedge clk); #1;
    tblWrEn = 1'b0;
    if (apply) begin
      if (!sel) begin if (addr < 255) mdlNode[addr] = data; end
      else mdlOwner[addr] = data[2:0];
    end
  endtask

  task automatic lookup(input logic [11:0] id, input logic [2:0] own, input string tag);
    int expVis, cnt;
    bit expMis;
    int expSlot = refLookup(id, own, expVis, expMis);
    @(negedge clk);
    reqValid = 1'b1; reqId = id; reqOwner = own;
    @(negedge clk);
    reqValid = 1'b0;
    cnt = 0;
    while (!rspValid && cnt < 40) begin @(negedge clk); cnt++; end
    checkEq({tag, " slot"}, int'(rspSlot), expSlot);
    checkEq({tag, " mismatch R6"}, int'(rspOwnerMismatch), int'(expMis));
    checkEq({tag, " latency R7"}, cnt, expVis);
  endtask

  task automatic fillRandom();
    for (int i = 0; i < 255; i++)
      wr(0, i, mkNode($urandom % 16, ($urandom % 5) < 3, $urandom % 256,
                      ($urandom % 5) < 3, $urandom % 256), 1);
    for (int s = 0; s < 256; s++) wr(1, s, 32'($urandom % 2), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    checkEq("R1 rspValid after reset", int'(rspValid), 0);
    checkEq("R1 reqReady after reset", int'(reqReady), 1);
    rstN = 1'b1;
    repeat (2) @(posedge clk);

    for (int s = 0; s < 256; s++) wr(1, s, 32'd0, 1);

    // R2 R3: bit 13 reads 0, zero branch terminal to 5
    wr(0, 0, mkNode(13, 0, 5, 0, 6), 1);
    lookup(12'hFFF, 3'd0, "R2 high bit index");
    checkEq("R2 high bit result", int'(rspSlot), 5);
    // R3: bit 3 selects one branch
    wr(0, 0, mkNode(3, 0, 7, 1, 2), 1);
    wr(0, 2, mkNode(0, 0, 40, 0, 41), 1);
    lookup(12'h009, 3'd0, "R3 two level one");
    checkEq("R3 two level slot", int'(rspSlot), 41);
    lookup(12'h001, 3'd0, "R3 zero branch");
    // R6 owner mismatch, R10 owner from low bits only
    wr(1, 41, 32'hFFFF_FFFB, 1);
    lookup(12'h009, 3'd0, "R6 mismatch");
    checkEq("R6 mismatch flag", int'(rspOwnerMismatch), 1);
    lookup(12'h009, 3'd3, "R10 owner low bits");
    checkEq("R10 owner match slot", int'(rspSlot), 41);

    // R4: chain of 16, terminal on last visit
    for (int i = 0; i < 15; i++) wr(0, i, mkNode(0, 1, i + 1, 1, i + 1), 1);
    wr(0, 15, mkNode(0, 0, 77, 0, 77), 1);
    lookup(12'h000, 3'd0, "R4 terminal on 16th");
    checkEq("R4 16th visit slot", int'(rspSlot), 77);
    // R4: self loop fails
    wr(0, 0, mkNode(0, 1, 0, 1, 0), 1);
    lookup(12'h000, 3'd0, "R4 loop limit");
    checkEq("R4 limit code", int'(rspSlot), 256);
    // R5: jump to 255
    wr(0, 0, mkNode(0, 1, 255, 1, 255), 1);
    lookup(12'h000, 3'd0, "R5 bad index");
    checkEq("R5 bad index flag", int'(rspOwnerMismatch), 0);

    // R8 R9: traffic during a long walk
    wr(0, 0, mkNode(0, 1, 0, 1, 0), 1);
    wr(1, 9, 32'd0, 1);
    @(negedge clk);
    reqValid = 1'b1; reqId = 12'h000; reqOwner = 3'd0;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    checkEq("R8 busy during walk", int'(reqReady), 0);
    reqValid = 1'b1; reqId = 12'h123;
    tblWrEn = 1'b1; tblWrSel = 1'b0; tblWrAddr = 8'd0; tblWrData = mkNode(0, 0, 9, 0, 9);
    @(negedge clk);
    tblWrSel = 1'b1; tblWrAddr = 8'd9; tblWrData = 32'd5;
    @(negedge clk);
    tblWrEn = 1'b0; reqValid = 1'b0;
    begin
      int cnt = 0;
      while (!rspValid && cnt < 40) begin @(negedge clk); cnt++; end
      checkEq("R8 first walk slot", int'(rspSlot), 256);
      cnt = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (rspValid) cnt++; end
      checkEq("R8 dropped request gave no response", cnt, 0);
      checkEq("R7 slot held", int'(rspSlot), 256);
      checkEq("R8 ready after walk", int'(reqReady), 1);
    end
    lookup(12'h000, 3'd0, "R9 node write ignored");
    wr(0, 0, mkNode(0, 0, 9, 0, 9), 1);
    lookup(12'h000, 3'd0, "R9 owner write ignored");
    checkEq("R9 owner still 0", int'(rspSlot), 9);

    // Random trees
    for (int f = 0; f < 3; f++) begin
      fillRandom();
      for (int k = 0; k < 100; k++)
        lookup(12'($urandom), 3'($urandom % 2), "R3 random walk");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule